// File: doc/BRIEF.md
# ADC Offset and Gain Corrector

This block sits on a stream of signed ADC conversion codes and removes the system's offset and gain error digitally. The host runs two calibration steps. In the zero step the analog input is held at zero, and the block averages a fixed number of incoming codes into a stored zero point. In the gain step a known calibration input is applied, and the host supplies the ideal code for that input. The block averages the same number of codes into a measured code. It then divides the measured code, less the zero point, by the ideal code to get a gain ratio.

In run mode each incoming code has the zero point subtracted. The result is divided by the gain ratio and clamped to the signed word range, then presented on a valid/ready output. One sequential divider serves both the ratio computation and the per-sample correction. While that divider runs, the block raises a busy flag and accepts neither samples nor commands.

Top module: `adc_cal_corrector`

## Requirements
- R1: After reset the zero point is 0 and the gain ratio is exactly 1.0, so a corrected code equals the input code; out_valid and busy are low and cmd_ready is high.
- R2: Command code 2'b01 on cmd_op starts a zero capture. The next 2^AVG_LOG2 accepted samples are summed, and the sum shifted arithmetically right by AVG_LOG2 (floor) becomes the zero point. These samples produce no output.
- R3: Command code 2'b10 on cmd_op latches cmd_ideal (unsigned) and starts a gain capture. The next 2^AVG_LOG2 samples are averaged as in R2 into the measured code M. The gain ratio becomes floor((M - zero point) * 2^16 / ideal), held unsigned with 16 fractional bits, and raised to 1 LSB if it comes out as 0.
- R4: If M minus the zero point is zero or negative, or the ideal code is 0, the gain capture leaves the gain ratio unchanged.
- R5: In run mode an accepted sample x yields sign(d) * floor(|d| * 2^16 / ratio), where d = x - zero point is taken at full precision.
- R6: A corrected value above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) is clamped to that limit rather than wrapping.
- R7: While the divider runs, busy is high and both in_ready and cmd_ready are low.
- R8: A command presented while a correction is in progress is held, with cmd_ready low, until its output has been accepted. In run mode a pending command takes priority over a sample, so in_ready is low while cmd_valid is high.
- R9: Once out_valid rises, out_valid and out_data hold steady until out_ready is seen high.
- R10: Command codes 2'b00 and 2'b11 are accepted and change neither the zero point nor the gain ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Calibration command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_op | input | 2 | Command code: 01 zero capture, 10 gain capture |
| cmd_ideal | input | DATA_W | Ideal code for the gain capture, unsigned |
| in_valid | input | 1 | Conversion code offered |
| in_ready | output | 1 | Block can take a code |
| in_data | input | DATA_W | Signed conversion code |
| out_valid | output | 1 | Corrected code available |
| out_ready | input | 1 | Downstream takes the corrected code |
| out_data | output | DATA_W | Signed corrected code |
| busy | output | 1 | Sequential divider running |

## Verification
The bench covers four error cases.
- Negative averages must round toward minus infinity. A design that divides the sum by truncation would store a zero point one code too high.
- A gain capture whose measured code does not exceed the zero point, or whose ideal code is zero, must keep the previous ratio. A design that divided anyway would corrupt every later output or divide by zero.
- Inputs far from the zero point, combined with a ratio below one, push both signs past the word range. These cases expose a wrap instead of a clamp, and an off-by-one at the exact negative limit.
- The bench holds a command against a pending output and delays out_ready at random. A design that let the command through early, or changed out_data before the handshake, would show it here.

// File: rtl/adc_cal_pkg.sv
// Package: shared state encoding and command codes for the offset/gain corrector.
// Assumes: consumers import it; no logic here.
package adc_cal_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_CAPZ,
        ST_CAPG,
        ST_GDIV,
        ST_CDIV,
        ST_OUT
    } cal_state_e;

    localparam logic [1:0] OP_ZERO = 2'b01;
    localparam logic [1:0] OP_GAIN = 2'b10;

endpackage

// File: rtl/adc_cal_avg.sv
// Module: power-of-two sample averager.
// Accumulates 2^AVG_LOG2 signed samples. It flags the last one and presents the floor
// mean (arithmetic shift) including the current sample, so the caller can latch it.
// Assumes: clr and add are never high in the same cycle.
module adc_cal_avg #(
    parameter int DATA_W   = 16,
    parameter int AVG_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add,
    input  logic signed [DATA_W-1:0] sample,
    output logic                     last,
    output logic signed [DATA_W-1:0] mean
);
    localparam int N     = 1 << AVG_LOG2;
    localparam int ACC_W = DATA_W + AVG_LOG2;
    localparam int CNT_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum_nxt;
    logic [CNT_W-1:0]        cnt_q;

    // Running sum including the sample offered now, and its floor mean.
    always_comb begin
        sum_nxt = acc_q + ACC_W'(sample);
        mean    = DATA_W'(sum_nxt >>> AVG_LOG2);
        last    = (cnt_q == CNT_W'(N - 1));
    end

    // Accumulator and sample counter; both restart after the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            if (last) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= sum_nxt;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/adc_cal_div.sv
// Module: unsigned restoring divider, one quotient bit per cycle.
// start loads operands; after NUM_W cycles done pulses for one cycle and quot holds
// the quotient until the next start. Divisor 0 yields all ones.
// Assumes: start is not raised while running.
module adc_cal_div #(
    parameter int NUM_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [NUM_W-1:0] divisor,
    output logic             running,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] rem_q;
    logic [NUM_W-1:0] dsr_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [NUM_W:0]   trial;
    logic             ge;

    // Shift in the next dividend bit and test against the divisor.
    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        ge    = (trial >= {1'b0, dsr_q});
    end

    // Iteration registers and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            dsr_q   <= '0;
            quo_q   <= '0;
            cnt_q   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q   <= '0;
                dsr_q   <= divisor;
                quo_q   <= dividend;
                cnt_q   <= CNT_W'(NUM_W);
                running <= 1'b1;
            end else if (running) begin
                rem_q <= ge ? NUM_W'(trial - {1'b0, dsr_q}) : trial[NUM_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], ge};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign quot = quo_q;

    // R7: a new division never starts on top of one in progress.
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);
    // R7: completion is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/adc_cal_corrector.sv
// Module: ADC offset and gain corrector (top).
// Zero and gain captures average 2^AVG_LOG2 samples. The gain ratio (Q.FRAC_W, unsigned)
// = (measured - zero)/ideal. Run mode outputs clamp((x - zero)/ratio) over valid/ready.
// Assumes: one shared sequential divider; commands wait for any pending output.
module adc_cal_corrector #(
    parameter int DATA_W   = 16,
    parameter int AVG_LOG2 = 2,
    parameter int FRAC_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [1:0]               cmd_op,
    input  logic [DATA_W-1:0]        cmd_ideal,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [DATA_W-1:0] out_data,
    output logic                     busy
);
    import adc_cal_pkg::*;

    localparam int DIFF_W = DATA_W + 1;
    localparam int NUM_W  = DIFF_W + FRAC_W;
    localparam logic [NUM_W-1:0] RATIO_ONE = NUM_W'(1) << FRAC_W;
    localparam logic [NUM_W-1:0] POS_LIM   = NUM_W'({(DATA_W-1){1'b1}});
    localparam logic [NUM_W-1:0] NEG_LIM   = POS_LIM + NUM_W'(1);

    cal_state_e               state_q;
    logic signed [DATA_W-1:0] zp_q;
    logic [NUM_W-1:0]         ratio_q;
    logic [DATA_W-1:0]        ideal_q;
    logic                     neg_q;
    logic signed [DATA_W-1:0] out_q;

    logic                     cmd_fire, in_fire, capturing;
    logic                     avg_last;
    logic signed [DATA_W-1:0] avg_mean;
    logic signed [DIFF_W-1:0] diff_in, gdiff;
    logic [DIFF_W-1:0]        mag_in;
    logic                     gain_ok;
    logic                     div_start, div_running, div_done;
    logic [NUM_W-1:0]         div_num, div_den, div_quot;
    logic signed [DATA_W-1:0] sat_val;

    // Handshake readiness derived from the control state.
    always_comb begin
        capturing = (state_q == ST_CAPZ) || (state_q == ST_CAPG);
        cmd_ready = (state_q == ST_RUN);
        in_ready  = ((state_q == ST_RUN) && !cmd_valid) || capturing;
        cmd_fire  = cmd_valid && cmd_ready;
        in_fire   = in_valid && in_ready;
        busy      = (state_q == ST_GDIV) || (state_q == ST_CDIV);
        out_valid = (state_q == ST_OUT);
        out_data  = out_q;
    end

    // Offset removal at full precision and the gain-capture numerator.
    always_comb begin
        diff_in = {in_data[DATA_W-1], in_data} - {zp_q[DATA_W-1], zp_q};
        mag_in  = diff_in[DIFF_W-1] ? (~diff_in + DIFF_W'(1)) : diff_in;
        gdiff   = {avg_mean[DATA_W-1], avg_mean} - {zp_q[DATA_W-1], zp_q};
        gain_ok = !gdiff[DIFF_W-1] && (gdiff != '0) && (ideal_q != '0);
    end

    // Divider operand selection: correction in run mode, ratio otherwise.
    always_comb begin
        div_start = ((state_q == ST_RUN) && in_fire) ||
                    ((state_q == ST_CAPG) && in_fire && avg_last && gain_ok);
        if (state_q == ST_RUN) begin
            div_num = {mag_in, {FRAC_W{1'b0}}};
            div_den = ratio_q;
        end else begin
            div_num = {gdiff, {FRAC_W{1'b0}}};
            div_den = {{(NUM_W-DATA_W){1'b0}}, ideal_q};
        end
    end

    // Clamp the signed quotient into the output word range.
    always_comb begin
        if (neg_q) begin
            sat_val = (div_quot > NEG_LIM) ? {1'b1, {(DATA_W-1){1'b0}}}
                                           : ~div_quot[DATA_W-1:0] + DATA_W'(1);
        end else begin
            sat_val = (div_quot > POS_LIM) ? {1'b0, {(DATA_W-1){1'b1}}}
                                           : div_quot[DATA_W-1:0];
        end
    end

    adc_cal_avg #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) i_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cmd_fire),
        .add    (in_fire && capturing),
        .sample (in_data),
        .last   (avg_last),
        .mean   (avg_mean)
    );

    adc_cal_div #(.NUM_W(NUM_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_num),
        .divisor  (div_den),
        .running  (div_running),
        .done     (div_done),
        .quot     (div_quot)
    );

    // Control sequencer and calibration state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            zp_q    <= '0;
            ratio_q <= RATIO_ONE;
            ideal_q <= '0;
            neg_q   <= 1'b0;
            out_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (cmd_fire) begin
                        if (cmd_op == OP_ZERO) begin
                            state_q <= ST_CAPZ;
                        end else if (cmd_op == OP_GAIN) begin
                            state_q <= ST_CAPG;
                            ideal_q <= cmd_ideal;
                        end
                    end else if (in_fire) begin
                        neg_q   <= diff_in[DIFF_W-1];
                        state_q <= ST_CDIV;
                    end
                end
                ST_CAPZ: begin
                    if (in_fire && avg_last) begin
                        zp_q    <= avg_mean;
                        state_q <= ST_RUN;
                    end
                end
                ST_CAPG: begin
                    if (in_fire && avg_last) begin
                        state_q <= gain_ok ? ST_GDIV : ST_RUN;
                    end
                end
                ST_GDIV: begin
                    if (div_done) begin
                        ratio_q <= (div_quot == '0) ? NUM_W'(1) : div_quot;
                        state_q <= ST_RUN;
                    end
                end
                ST_CDIV: begin
                    if (div_done) begin
                        out_q   <= sat_val;
                        state_q <= ST_OUT;
                    end
                end
                ST_OUT: begin
                    if (out_ready) begin
                        state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // R7: the divider only runs in a busy state, and busy blocks both inputs.
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (div_running |-> busy) and (busy |-> (!in_ready && !cmd_ready)));
    // R8: no command slips in while an output waits.
    a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);
    // R9: output held steady until accepted.
    a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R3: the stored ratio is never zero, so correction never divides by zero.
    a_r3_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q != '0);

endmodule

// File: tb/test_adc_cal_corrector.sv
`timescale 1ns/1ps
module test_adc_cal_corrector;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic [W-1:0] cmd_ideal = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [W-1:0] out_data;
    logic busy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    longint zp_m = 0;
    longint ratio_m = 65536;

    always #2.5 clk = ~clk;

    adc_cal_corrector i_adc_cal_corrector (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ideal(cmd_ideal),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint m_correct(input longint x);
        longint d, q;
        d = x - zp_m;
        q = ((d < 0 ? -d : d) <<< 16) / ratio_m;
        if (d < 0) q = -q;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    function automatic longint m_avg(input longint s0, input longint s1, input longint s2,
                                     input longint s3);
        return (s0 + s1 + s2 + s3) >>> 2;
    endfunction

    task automatic send_cmd(input logic [1:0] op, input logic [W-1:0] ideal);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ideal = ideal;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic send_sample(input longint x);
        @(negedge clk);
        in_valid = 1'b1; in_data = W'(x);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic get_out(output longint y);
        int dly;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        y = out_data;
        dly = $urandom_range(0, 2);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check("R9 hold", {out_valid, out_data}, {1'b1, W'(y)});
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    // Run-mode correction with the R7 busy check right after acceptance.
    task automatic correct(input longint x, input string req);
        longint y;
        send_sample(x);
        @(negedge clk);
        check("R7 busy", {busy, in_ready, cmd_ready}, 3'b100);
        get_out(y);
        check(req, y, m_correct(x));
    endtask

    task automatic cal_zero(input longint s0, input longint s1, input longint s2,
                            input longint s3);
        send_cmd(2'b01, '0);
        send_sample(s0); send_sample(s1); send_sample(s2); send_sample(s3);
        @(negedge clk);
        check("R2 no output during capture", out_valid, 0);
        zp_m = m_avg(s0, s1, s2, s3);
    endtask

    task automatic cal_gain(input longint ideal, input longint s0, input longint s1,
                            input longint s2, input longint s3);
        longint cr, d, r;
        send_cmd(2'b10, W'(ideal));
        send_sample(s0); send_sample(s1); send_sample(s2); send_sample(s3);
        cr = m_avg(s0, s1, s2, s3);
        d = cr - zp_m;
        if (d > 0 && ideal != 0) begin
            r = (d <<< 16) / ideal;
            ratio_m = (r == 0) ? 1 : r;
        end
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        longint y0;
        longint x;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 busy", busy, 0);
        check("R1 cmd_ready", cmd_ready, 1);
        correct(32767, "R1 identity max");
        correct(-32768, "R1 identity min");
        correct(-5, "R1 identity");

        // R8 priority: pending command blocks samples in run mode.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; in_valid = 1'b1; in_data = 16'sd7;
        @(negedge clk);
        check("R8 cmd over sample", in_ready, 0);
        @(posedge clk); #1 cmd_valid = 1'b0; in_valid = 1'b0;

        // R2 negative average rounds toward minus infinity.
        cal_zero(-1, -2, -2, -2);
        check("R2 floor mean model", zp_m, -2);
        correct(0, "R2 zero point applied");
        correct(100, "R2 zero point applied");

        // R3 gain ratio, then random corrections R5.
        cal_zero(longint'($urandom_range(0, 400)) - 200, longint'($urandom_range(0, 400)) - 200,
                 longint'($urandom_range(0, 400)) - 200, longint'($urandom_range(0, 400)) - 200);
        cal_gain(20000, 21000 + $urandom_range(0, 2000), 21000 + $urandom_range(0, 2000),
                 21000 + $urandom_range(0, 2000), 21000 + $urandom_range(0, 2000));
        correct(zp_m, "R3 zero in zero out");
        for (int i = 0; i < 40; i++) begin
            x = longint'($urandom_range(0, 65535)) - 32768;
            correct(x, "R5 random correction");
        end

        // R4 non-positive gain difference and zero ideal keep the ratio.
        cal_gain(20000, zp_m, zp_m, zp_m, zp_m);
        correct(12345, "R4 ratio kept on zero diff");
        cal_gain(20000, zp_m - 50, zp_m - 50, zp_m - 50, zp_m - 50);
        correct(-12345, "R4 ratio kept on negative diff");
        cal_gain(0, zp_m + 900, zp_m + 900, zp_m + 900, zp_m + 900);
        correct(22222, "R4 ratio kept on zero ideal");

        // R10 unused command codes change nothing.
        send_cmd(2'b00, 16'd5);
        send_cmd(2'b11, 16'd5);
        correct(3000, "R10 no effect");

        // R6 saturation with ratio 0.5.
        cal_zero(0, 0, 0, 0);
        cal_gain(30000, 15000, 15000, 15000, 15000);
        check("R3 ratio half model", ratio_m, 32768);
        correct(20000, "R6 clamp positive");
        correct(-20000, "R6 clamp negative");
        correct(-16384, "R6 exact negative limit");
        correct(16383, "R6 just below positive limit");
        correct(16384, "R6 just above positive limit");

        // R8 command held while output pending; R9 stability.
        send_sample(1000);
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        y0 = out_data;
        cmd_valid = 1'b1; cmd_op = 2'b01;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 cmd held", cmd_ready, 0);
            check("R9 data stable", out_data, y0);
        end
        check("R5 held output value", y0, m_correct(1000));
        out_ready = 1'b1;
        @(posedge clk); #1 out_ready = 1'b0;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #1 cmd_valid = 1'b0;
        send_sample(40); send_sample(40); send_sample(40); send_sample(40);
        zp_m = 40;
        correct(-30000, "R8 held command then applied");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule